// File: doc/BRIEF.md
# Return-from-Event Control Unit

This unit carries out the return-from-event step of a core event controller with sixteen priority levels. On a request it takes the target level and the current pending-event word. It then decides whether the return is allowed from the level the core is running at. An accepted return does several things in one clock edge:

- it sends out the saved return address of the target level, with bit 0 cleared, as the new program counter;
- it writes back an updated pending word;
- it clears the global interrupt-disable flag when the target level calls for it;
- when no event is left pending, it swaps the kernel and user stack pointers.

A rejected request changes no state. It raises an illegal-use exception request, or a fatal flag when the target is the global-enable slot.

The surrounding core supplies the sixteen saved return addresses as one flat bus, with level n in bits n*AW upward. It writes the stack, loop-bottom and disable registers through a small write port. It uses the pending-check strobe to re-evaluate waiting events once a return has completed. Levels are fixed: 0 emulation, 1 reset, 2 NMI, 3 exception, 4 global-enable slot, 5 hardware error, 6 to 15 general interrupts.

Top module: `rfe_ctrl`

## Requirements
- R1: After reset, `sp`, `ksp` and `usp` all equal the SCRATCH_TOP parameter. `lb0`, `lb1`, `pend_out` and `gdis` are 0, `syscfg` reads 0x30, and `done`, `exc_req`, `fatal` and `pend_chk` are low.
- R2: The current level is the lowest-numbered set bit among bits 15..1 of `pend_in`; bit 0 is ignored. With none set the core is in user mode, and any request then gives `exc_req` high for one cycle and changes no register.
- R3: Target 2 is accepted only at current level 2, and target 3 only at current level 3. Target 0 is accepted only at the emulation level, which R2 never reports, so target 0 is always rejected with `exc_req`.
- R4: A target of 1 or 5..15 is rejected with `exc_req` when the current level is 2, 3 or user mode, and is accepted at any other current level.
- R5: Target 4 at a non-user current level gives `fatal` high for one cycle and changes no register.
- R6: The cycle after an accepted request, `done` is high for one cycle and `new_pc` equals the saved address of the target level with bit 0 forced to 0. Exactly one of `done`, `exc_req` and `fatal` answers each request.
- R7: On acceptance, `pend_out` becomes `pend_in` with bit 0 cleared. The target level's bit is also cleared if bit 0 of its saved address is 0, and kept if that bit is 1. `pend_out` changes on no other event.
- R8: An accepted return to level 1 or to any level 5..15 clears `gdis`. Other accepted returns leave it unchanged.
- R9: When the updated pending word is zero, the same edge does three things: it clears bit 0 of `lb0` and `lb1`, it loads `ksp` with the old `sp`, and it loads `sp` with `usp`.
- R10: `pend_chk` is high for one cycle, in the cycle right after each `done` pulse, and at no other time.
- R11: With `wr_en` high and `req_valid` low, the next edge writes `wr_data` into the register that `wr_sel` picks: 0 `sp`, 1 `ksp`, 2 `usp`, 3 `lb0`, 4 `lb1`, 5 `gdis` (from bit 0). Codes 6 and 7 write nothing. A write is dropped while `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Return request this cycle |
| req_lvl | input | 4 | Target level of the return |
| pend_in | input | 16 | Current pending-event word |
| ret_flat | input | 16*AW | Saved return addresses, level n at bits n*AW upward |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | AW | Write data |
| done | output | 1 | Accepted return, one-cycle pulse |
| new_pc | output | AW | New program counter |
| exc_req | output | 1 | Illegal-use exception request |
| fatal | output | 1 | Return aimed at the global-enable slot |
| pend_chk | output | 1 | Re-evaluate pending events |
| pend_out | output | 16 | Updated pending-event word |
| sp | output | AW | Current stack pointer |
| ksp | output | AW | Kernel stack pointer |
| usp | output | AW | User stack pointer |
| lb0 | output | AW | Loop-bottom register 0 |
| lb1 | output | AW | Loop-bottom register 1 |
| gdis | output | 1 | Global interrupt-disable flag |
| syscfg | output | 32 | System configuration value |

## Verification
The assertions assume that `pend_in`, `req_lvl` and `ret_flat` are stable and known whenever `req_valid` is high. They also assume that a write and a request never fall in the same cycle when the write is meant to take effect. The bench changes all inputs only on the falling edge. It keeps `req_valid` and `wr_en` in separate cycles, except for one directed case that checks a write is dropped. Pending words are built by choosing a lowest set level and adding random higher bits, so that every current level, including user mode, turns up often. Half the targets match the current level, so accepted returns are as common as rejected ones.

// File: rtl/rfe_pkg.sv
// Package: shared level numbers and write-select codes for the return unit.
// Assumes a fixed sixteen-level event controller.
package rfe_pkg;
    localparam int NUM_LVL = 16;
    typedef logic [3:0] lvl_t;

    localparam lvl_t LVL_EMU  = 4'd0;
    localparam lvl_t LVL_RST  = 4'd1;
    localparam lvl_t LVL_NMI  = 4'd2;
    localparam lvl_t LVL_EVX  = 4'd3;
    localparam lvl_t LVL_GEN  = 4'd4;
    localparam lvl_t LVL_HWE  = 4'd5;

    typedef enum logic [2:0] {
        WS_SP   = 3'd0,
        WS_KSP  = 3'd1,
        WS_USP  = 3'd2,
        WS_LB0  = 3'd3,
        WS_LB1  = 3'd4,
        WS_GDIS = 3'd5
    } wsel_t;
endpackage

// File: rtl/rfe_level_find.sv
// Module: finds the running level from the pending word.
// Input is pending bits 15..1 (bit 0 is excluded by the caller).
// Assumes the lowest set index wins; found=0 means user mode.
module rfe_level_find
    import rfe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LVL-1:1]   pend_hi,
    output logic                 found,
    output lvl_t                 lvl
);
    // Scan from the top down so the lowest set bit is the last to write.
    always_comb begin
        found = 1'b0;
        lvl   = LVL_EMU;
        for (int i = NUM_LVL - 1; i >= 1; i--) begin
            if (pend_hi[i]) begin
                found = 1'b1;
                lvl   = lvl_t'(i);
            end
        end
    end

    // R2
    lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (lvl != LVL_EMU) && pend_hi[lvl]);

    // R2
    user_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (pend_hi == '0));
endmodule

// File: rtl/rfe_legal_chk.sv
// Module: decides whether a return to a given target is allowed from the
// current level. Pure combinational; the caller registers the outcome.
// Assumes cur_lvl is meaningful only when in_user is low.
module rfe_legal_chk
    import rfe_pkg::*;
(
    input  logic in_user,
    input  lvl_t cur_lvl,
    input  lvl_t tgt,
    output logic illegal,
    output logic fatal_hit
);
    // Classify the request: user mode first, then the per-target rule.
    always_comb begin
        illegal   = 1'b0;
        fatal_hit = 1'b0;
        if (in_user) begin
            illegal = 1'b1;
        end else begin
            case (tgt)
                LVL_EMU: illegal = (cur_lvl != LVL_EMU);
                LVL_NMI: illegal = (cur_lvl != LVL_NMI);
                LVL_EVX: illegal = (cur_lvl != LVL_EVX);
                LVL_GEN: fatal_hit = 1'b1;
                default: illegal = (cur_lvl == LVL_EMU) ||
                                   (cur_lvl == LVL_NMI) ||
                                   (cur_lvl == LVL_EVX);
            endcase
        end
    end
endmodule

// File: rtl/rfe_stack_regs.sv
// Module: holds the stack pointers, loop-bottom registers and the global
// interrupt-disable flag. An accepted return takes priority over a write.
// Assumes wr_go is already qualified against a pending request.
module rfe_stack_regs
    import rfe_pkg::*;
#(
    parameter int          AW          = 32,
    parameter logic [AW-1:0] SCRATCH_TOP = 32'hFFB0_1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [2:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          upd,
    input  logic          to_user,
    input  logic          clr_gdis,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] ksp_q,
    output logic [AW-1:0] usp_q,
    output logic [AW-1:0] lb0_q,
    output logic [AW-1:0] lb1_q,
    output logic          gdis_q
);
    localparam logic [AW-1:0] LSB_CLR = ~AW'(1);

    wsel_t sel;
    assign sel = wsel_t'(wr_sel);

    // Stack and loop registers: return swap first, core write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= SCRATCH_TOP;
            ksp_q <= SCRATCH_TOP;
            usp_q <= SCRATCH_TOP;
            lb0_q <= '0;
            lb1_q <= '0;
        end else if (upd) begin
            if (to_user) begin
                ksp_q <= sp_q;
                sp_q  <= usp_q;
                lb0_q <= lb0_q & LSB_CLR;
                lb1_q <= lb1_q & LSB_CLR;
            end
        end else if (wr_go) begin
            case (sel)
                WS_SP:   sp_q  <= wr_data;
                WS_KSP:  ksp_q <= wr_data;
                WS_USP:  usp_q <= wr_data;
                WS_LB0:  lb0_q <= wr_data;
                WS_LB1:  lb1_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Disable flag: cleared by qualifying returns, else set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gdis_q <= 1'b0;
        end else if (upd) begin
            if (clr_gdis) gdis_q <= 1'b0;
        end else if (wr_go && sel == WS_GDIS) begin
            gdis_q <= wr_data[0];
        end
    end

    // R9
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd && to_user |=> (sp_q == $past(usp_q)) && (ksp_q == $past(sp_q)));

    // R9
    lb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd && to_user |=> !lb0_q[0] && !lb1_q[0]);

    // R8
    gdis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd && clr_gdis |=> !gdis_q);
endmodule

// File: rtl/rfe_ctrl.sv
// Module: top of the return-from-event unit. It registers one outcome per
// request (accept, exception or fatal) and, on accept, drives the new PC,
// the updated pending word and the stack-register changes together.
// Assumes request inputs are stable while req_valid is high.
module rfe_ctrl
    import rfe_pkg::*;
#(
    parameter int            AW          = 32,
    parameter logic [AW-1:0] SCRATCH_TOP = 32'hFFB0_1000,
    parameter logic [31:0]   SYSCFG_RST  = 32'h0000_0030
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [3:0]              req_lvl,
    input  logic [NUM_LVL-1:0]      pend_in,
    input  logic [NUM_LVL*AW-1:0]   ret_flat,
    input  logic                    wr_en,
    input  logic [2:0]              wr_sel,
    input  logic [AW-1:0]           wr_data,
    output logic                    done,
    output logic [AW-1:0]           new_pc,
    output logic                    exc_req,
    output logic                    fatal,
    output logic                    pend_chk,
    output logic [NUM_LVL-1:0]      pend_out,
    output logic [AW-1:0]           sp,
    output logic [AW-1:0]           ksp,
    output logic [AW-1:0]           usp,
    output logic [AW-1:0]           lb0,
    output logic [AW-1:0]           lb1,
    output logic                    gdis,
    output logic [31:0]             syscfg
);
    logic                 cur_found;
    lvl_t                 cur_lvl;
    logic                 illegal;
    logic                 fatal_hit;
    logic [AW-1:0]        ra;
    logic                 snen;
    logic [NUM_LVL-1:0]   pend_nx;
    logic                 accept;
    logic                 to_user;
    logic                 clr_gdis;
    logic                 wr_go;

    logic                 done_q;
    logic                 exc_q;
    logic                 fatal_q;
    logic                 chk_q;
    logic [AW-1:0]        pc_q;
    logic [NUM_LVL-1:0]   pend_q;

    rfe_level_find u_find (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_hi (pend_in[NUM_LVL-1:1]),
        .found   (cur_found),
        .lvl     (cur_lvl)
    );

    rfe_legal_chk u_legal (
        .in_user   (!cur_found),
        .cur_lvl   (cur_lvl),
        .tgt       (req_lvl),
        .illegal   (illegal),
        .fatal_hit (fatal_hit)
    );

    // Pick the saved address of the target and its self-nesting flag.
    always_comb begin
        ra   = ret_flat[req_lvl*AW +: AW];
        snen = ra[0];
    end

    // Next pending word: drop emulation bit, drop target unless self-nesting.
    always_comb begin
        pend_nx    = pend_in;
        pend_nx[0] = 1'b0;
        if (!snen) pend_nx[req_lvl] = 1'b0;
    end

    // Request qualification shared by the outcome and stack registers.
    always_comb begin
        accept   = req_valid && !illegal && !fatal_hit;
        to_user  = (pend_nx == '0);
        clr_gdis = (req_lvl >= LVL_HWE) || (req_lvl == LVL_RST);
        wr_go    = wr_en && !req_valid;
    end

    // Outcome pulses, new PC and pending word, one edge per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            exc_q   <= 1'b0;
            fatal_q <= 1'b0;
            chk_q   <= 1'b0;
            pc_q    <= '0;
            pend_q  <= '0;
        end else begin
            done_q  <= accept;
            exc_q   <= req_valid && illegal;
            fatal_q <= req_valid && fatal_hit;
            chk_q   <= done_q;
            if (accept) begin
                pc_q   <= {ra[AW-1:1], 1'b0};
                pend_q <= pend_nx;
            end
        end
    end

    rfe_stack_regs #(
        .AW          (AW),
        .SCRATCH_TOP (SCRATCH_TOP)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .upd      (accept),
        .to_user  (to_user),
        .clr_gdis (clr_gdis),
        .sp_q     (sp),
        .ksp_q    (ksp),
        .usp_q    (usp),
        .lb0_q    (lb0),
        .lb1_q    (lb1),
        .gdis_q   (gdis)
    );

    assign done     = done_q;
    assign exc_req  = exc_q;
    assign fatal    = fatal_q;
    assign pend_chk = chk_q;
    assign new_pc   = pc_q;
    assign pend_out = pend_q;
    assign syscfg   = SYSCFG_RST;

    // R6
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_q, exc_q, fatal_q}));

    // R6
    pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !pc_q[0]);

    // R10
    pend_chk_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> chk_q);

    // R10
    pend_chk_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q |-> $past(done_q));

    // R2
    user_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (pend_in[NUM_LVL-1:1] == '0) |=> exc_q);

    // R3
    nmi_wrong_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_lvl == LVL_NMI) && !pend_in[LVL_NMI] |=> exc_q);

    // R5
    gen_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_lvl == LVL_GEN) && (pend_in[NUM_LVL-1:1] != '0)
        |=> fatal_q);

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(pend_q));
endmodule

// File: tb/rfe_ctrl_tb.sv
`timescale 1ns/1ps
module rfe_ctrl_tb_top;
    localparam int AW = 32;
    localparam int NL = 16;
    localparam logic [AW-1:0] TOP = 32'hFFB0_1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [3:0]        req_lvl = '0;
    logic [NL-1:0]     pend_in = '0;
    logic [NL*AW-1:0]  ret_flat = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_sel = '0;
    logic [AW-1:0]     wr_data = '0;
    logic              done, exc_req, fatal, pend_chk, gdis;
    logic [AW-1:0]     new_pc, sp, ksp, usp, lb0, lb1;
    logic [NL-1:0]     pend_out;
    logic [31:0]       syscfg;

    int n_chk = 0;
    int n_fail = 0;

    logic [AW-1:0] m_sp, m_ksp, m_usp, m_lb0, m_lb1, m_pc;
    logic          m_gdis;
    logic [NL-1:0] m_pend;

    always #2.5 clk = ~clk;

    rfe_ctrl #(.AW(AW), .SCRATCH_TOP(TOP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lvl(req_lvl),
        .pend_in(pend_in), .ret_flat(ret_flat), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .done(done), .new_pc(new_pc),
        .exc_req(exc_req), .fatal(fatal), .pend_chk(pend_chk),
        .pend_out(pend_out), .sp(sp), .ksp(ksp), .usp(usp), .lb0(lb0),
        .lb1(lb1), .gdis(gdis), .syscfg(syscfg)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic int cur_of(input logic [NL-1:0] p);
        int c = -1;
        for (int i = NL - 1; i >= 1; i--) if (p[i]) c = i;
        return c;
    endfunction

    // 0 accept, 1 exception, 2 fatal
    function automatic int outcome(input logic [NL-1:0] p, input int t);
        int c = cur_of(p);
        if (c < 0) return 1;
        case (t)
            0: return (c == 0) ? 0 : 1;
            2: return (c == 2) ? 0 : 1;
            3: return (c == 3) ? 0 : 1;
            4: return 2;
            default: return (c == 2 || c == 3) ? 1 : 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [NL-1:0] p, input int t);
        if (cur_of(p) < 0) return "R2";
        if (t == 4) return "R5";
        if (t == 0 || t == 2 || t == 3) return "R3";
        return "R4";
    endfunction

    task automatic check_regs(input string tag);
        chk(tag, "sp", 64'(sp), 64'(m_sp));
        chk(tag, "ksp", 64'(ksp), 64'(m_ksp));
        chk(tag, "usp", 64'(usp), 64'(m_usp));
        chk(tag, "lb0", 64'(lb0), 64'(m_lb0));
        chk(tag, "lb1", 64'(lb1), 64'(m_lb1));
        chk(tag, "gdis", 64'(gdis), 64'(m_gdis));
    endtask

    task automatic set_ra(input int l, input logic [AW-1:0] v);
        ret_flat[l*AW +: AW] = v;
    endtask

    task automatic wr(input int s, input logic [AW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(s); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (s)
            0: m_sp = d;
            1: m_ksp = d;
            2: m_usp = d;
            3: m_lb0 = d;
            4: m_lb1 = d;
            5: m_gdis = d[0];
            default: ;
        endcase
        check_regs("R11");
    endtask

    task automatic do_ret(input logic [NL-1:0] p, input int t);
        int oc;
        logic [NL-1:0] pn;
        logic [AW-1:0] ra, old_sp;
        string tg;
        oc = outcome(p, t);
        tg = tag_of(p, t);
        ra = ret_flat[t*AW +: AW];
        @(negedge clk);
        pend_in = p; req_lvl = 4'(t); req_valid = 1'b1;
        if (oc == 0) begin
            pn = p; pn[0] = 1'b0;
            if (!ra[0]) pn[t] = 1'b0;
            m_pend = pn;
            m_pc = {ra[AW-1:1], 1'b0};
            if (t >= 5 || t == 1) m_gdis = 1'b0;
            if (pn == '0) begin
                old_sp = m_sp;
                m_sp = m_usp; m_ksp = old_sp;
                m_lb0[0] = 1'b0; m_lb1[0] = 1'b0;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6", "done", 64'(done), 64'(oc == 0));
        chk(tg, "exc_req", 64'(exc_req), 64'(oc == 1));
        chk("R5", "fatal", 64'(fatal), 64'(oc == 2));
        if (oc == 0) chk("R6", "new_pc", 64'(new_pc), 64'(m_pc));
        chk("R7", "pend_out", 64'(pend_out), 64'(m_pend));
        chk("R8", "gdis", 64'(gdis), 64'(m_gdis));
        check_regs("R9");
        @(negedge clk);
        chk("R10", "pend_chk", 64'(pend_chk), 64'(oc == 0));
    endtask

    function automatic logic [NL-1:0] rand_pend();
        int l;
        logic [NL-1:0] p;
        if ($urandom % 5 == 0) return NL'($urandom % 2);
        l = 1 + ($urandom % (NL - 1));
        p = NL'($urandom) & (~NL'(0) << l);
        p[l] = 1'b1;
        p[0] = 1'($urandom);
        return p;
    endfunction

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NL; i++) set_ra(i, 32'h1000_0000 + 32'(i * 16));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_sp = TOP; m_ksp = TOP; m_usp = TOP; m_lb0 = '0; m_lb1 = '0;
        m_gdis = 1'b0; m_pend = '0; m_pc = '0;
        // R1 reset state
        chk("R1", "syscfg", 64'(syscfg), 64'h30);
        chk("R1", "sp", 64'(sp), 64'(TOP));
        chk("R1", "ksp", 64'(ksp), 64'(TOP));
        chk("R1", "usp", 64'(usp), 64'(TOP));
        chk("R1", "pend_out", 64'(pend_out), 64'h0);
        chk("R1", "outputs", 64'({done, exc_req, fatal, pend_chk, gdis}), 64'h0);

        // R11 writes, ignored select, dropped during request
        wr(2, 32'h0000_8000);
        wr(3, 32'h0000_2001);
        wr(4, 32'h0000_3001);
        wr(5, 32'h1);
        wr(6, 32'hDEAD_BEEF);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h1234_5678;
        pend_in = '0; req_lvl = 4'd6; req_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk("R11", "sp after dropped write", 64'(sp), 64'(m_sp));
        chk("R2", "exc_req", 64'(exc_req), 64'h1);

        // Directed corners
        do_ret(16'h0000, 6);   // R2 user mode
        do_ret(16'h0001, 0);   // R2 only emulation bit
        do_ret(16'h0003, 0);   // R3 emulation return rejected
        do_ret(16'h0018, 2);   // R3 NMI return at level 3
        do_ret(16'h0044, 6);   // R4 ordinary at NMI
        do_ret(16'h0048, 7);   // R4 ordinary at exception
        do_ret(16'h0020, 4);   // R5 fatal
        set_ra(2, 32'h2000_0003);
        do_ret(16'h0104, 2);   // R7 self-nesting keeps bit 2
        do_ret(16'h0008, 3);   // R7 R9 return to user
        wr(5, 32'h1);
        do_ret(16'h0024, 2);   // R8 gdis stays
        set_ra(5, 32'h5000_0010);
        do_ret(16'h0021, 5);   // R8 R9 clears gdis, back to user
        wr(5, 32'h1);
        do_ret(16'h0002, 1);   // R8 reset-level return clears gdis

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [NL-1:0] p;
            int t, c;
            for (int i = 0; i < NL; i++) set_ra(i, $urandom);
            if ($urandom % 8 == 0) wr($urandom % 7, $urandom);
            p = rand_pend();
            c = cur_of(p);
            if (c > 0 && ($urandom % 2 == 0)) t = c;
            else t = $urandom % NL;
            do_ret(p, t);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule